// File: doc/BRIEF.md
# Burst-of-two DDR SRAM front end

This block is a single-clock model of a common-I/O synchronous memory in which every command moves a pair of data beats. The two half-cycle beats of the external interface are presented as two consecutive beat slots: beat 0 first, then beat 1. Each stored word is twice the I/O width, so one address selects a beat pair. Incoming write beats are collected and written to the array in one access. A read fetches one array word and sends its low half out as beat 0 and its high half as beat 1.

Writes are late writes. The command comes first, and the two data beats follow on the next two cycles, each beat with its own active-low lane enables. The gathered word waits one more cycle in a pending register before it reaches the array. Reads look past the array into that pending register, lane by lane, so a read always sees the newest data.

The block produces a data-valid flag and a bus output-enable. Both are high only during the slots that carry read data, so a host can turn a shared data bus around safely.

Top module: `b2_sram_front`

## Requirements
- R1: A cycle with `ld_n` high is idle. The values on `rw`, `addr`, `din` and `bw_n` in that cycle change no stored word and cause no read output.
- R2: In a cycle with `ld_n` low, `rw` high starts a read and `rw` low starts a write.
- R3: The write beats arrive one and two cycles after the write command. The stored word at the command's address becomes {beat 1, beat 0}: beat 0 fills bits DQ_W-1:0 and beat 1 fills the upper half. Both halves are committed together.
- R4: `bw_n` is active low and is sampled with each data beat. Bit 0 gates data bits 8:0 and bit 1 gates bits 17:9 of that beat. A lane whose enable is high keeps its stored value.
- R5: A read's beat 0 (the low half of the word) appears on `dout` two cycles after the command. Beat 1 (the high half) follows in the next cycle.
- R6: A read issued while a write to the same address is still pending returns the stored word merged with that write's enabled lanes.
- R7: `dvalid` is high in exactly the cycles that carry read beats.
- R8: `dout_oe` is high in exactly the read beat cycles and never in a cycle in which a write beat is being captured.
- R9: While `rst_n` is low, and after reset until the first read, `dvalid` and `dout_oe` stay low.
- R10: Outside read beat cycles `dout` is all zeros.
- R11: All 2^ADDR_W addresses hold independent words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one beat slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_n | input | 1 | Active-low command strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Beat-pair address |
| din | input | DQ_W | Write data beat |
| bw_n | input | BYTES | Active-low lane enables for the current write beat |
| dout | output | DQ_W | Read data beat |
| dout_oe | output | 1 | Drive enable for a shared data bus |
| dvalid | output | 1 | High during read beat slots |

## Verification
The assertions assume a well-behaved host. Accepted commands are at least two cycles apart, because each command uses two beat slots. A write starts no earlier than three cycles after a read, so its beats never meet the read's output slots. The bench drives the block from a per-cycle schedule that enforces both gaps, including in its random phase. It fills idle cycles with random address, direction, data and lane enables, so the ignored inputs are exercised without breaking either rule. The directed cases put reads exactly two cycles after a write, and after two back-to-back writes to the same address, so that each read lands on a pending write.

// File: rtl/b2_pkg.sv
package b2_pkg;
  // which half of the fetched word the output stage is presenting
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_LO   = 2'd1,
    SLOT_HI   = 2'd2
  } rd_slot_e;
endpackage

// File: rtl/b2_rst_sync.sv
module b2_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/b2_wr_gather.sv
module b2_wr_gather #(
  parameter int DQ_W   = 18,
  parameter int BYTES  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_cmd,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [DQ_W-1:0]       din,
  input  logic [BYTES-1:0]      bw_n,
  output logic                  pend_v,
  output logic [ADDR_W-1:0]     pend_addr,
  output logic [2*DQ_W-1:0]     pend_data,
  output logic [2*BYTES-1:0]    pend_wen,
  output logic                  capturing
);
  localparam int WORD_W = 2 * DQ_W;
  localparam int WLANES = 2 * BYTES;

  logic              beat0_due_q, beat0_due_d;
  logic              beat1_due_q, beat1_due_d;
  logic              pend_v_q, pend_v_d;
  logic [ADDR_W-1:0] wa_q;
  logic [DQ_W-1:0]   b0_q;
  logic [BYTES-1:0]  m0_q;
  logic [ADDR_W-1:0] pa_q;
  logic [WORD_W-1:0] pd_q;
  logic [WLANES-1:0] pw_q;

  // next-state
  always_comb begin
    beat0_due_d = wr_cmd;
    beat1_due_d = beat0_due_q;
    pend_v_d    = beat1_due_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat0_due_q <= 1'b0;
      beat1_due_q <= 1'b0;
      pend_v_q    <= 1'b0;
    end else begin
      beat0_due_q <= beat0_due_d;
      beat1_due_q <= beat1_due_d;
      pend_v_q    <= pend_v_d;
    end
  end

  // data registers, enabled, not reset
  always_ff @(posedge clk) begin
    if (wr_cmd) wa_q <= cmd_addr;
    if (beat0_due_q) begin
      b0_q <= din;
      m0_q <= ~bw_n;
    end
    if (beat1_due_q) begin
      pa_q <= wa_q;
      pd_q <= {din, b0_q};
      pw_q <= {~bw_n, m0_q};
    end
  end

  assign pend_v    = pend_v_q;
  assign pend_addr = pa_q;
  assign pend_data = pd_q;
  assign pend_wen  = pw_q;
  assign capturing = beat0_due_q | beat1_due_q;

  // R3: a pending word exists only three cycles after a write command
  p_commit_after_beats_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> $past(wr_cmd, 3));
endmodule

// File: rtl/b2_array.sv
module b2_array #(
  parameter int DQ_W   = 18,
  parameter int BYTES  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  pend_v,
  input  logic [ADDR_W-1:0]     pend_addr,
  input  logic [2*DQ_W-1:0]     pend_data,
  input  logic [2*BYTES-1:0]    pend_wen,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [2*DQ_W-1:0]     rd_word
);
  localparam int WORD_W = 2 * DQ_W;
  localparam int WLANES = 2 * BYTES;
  localparam int LANE_W = DQ_W / BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] arr_word;
  logic              hit;

  // lane-wise commit of the pending word
  always_ff @(posedge clk) begin
    if (pend_v) begin
      for (int i = 0; i < WLANES; i++) begin
        if (pend_wen[i]) mem[pend_addr][i*LANE_W +: LANE_W] <= pend_data[i*LANE_W +: LANE_W];
      end
    end
  end

  assign arr_word = mem[rd_addr];
  assign hit      = pend_v && (pend_addr == rd_addr);

  // coherence: enabled lanes of a matching pending write override the array
  for (genvar g = 0; g < WLANES; g++) begin : g_byp
    assign rd_word[g*LANE_W +: LANE_W] = (hit && pend_wen[g]) ?
      pend_data[g*LANE_W +: LANE_W] : arr_word[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/b2_rd_out.sv
module b2_rd_out
  import b2_pkg::*;
#(
  parameter int DQ_W   = 18,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_cmd,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [2*DQ_W-1:0]   rd_word,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [DQ_W-1:0]     dout,
  output logic                dvalid,
  output logic                oe
);
  localparam int WORD_W = 2 * DQ_W;

  logic              fetch_q, fetch_d;
  rd_slot_e          slot_q, slot_d;
  logic [ADDR_W-1:0] ra_q;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    fetch_d = rd_cmd;
    if (fetch_q)                slot_d = SLOT_LO;
    else if (slot_q == SLOT_LO) slot_d = SLOT_HI;
    else                        slot_d = SLOT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      slot_q  <= SLOT_NONE;
    end else begin
      fetch_q <= fetch_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_cmd)  ra_q   <= cmd_addr;
    if (fetch_q) word_q <= rd_word;
  end

  assign rd_addr = ra_q;

  always_comb begin
    case (slot_q)
      SLOT_LO: dout = word_q[DQ_W-1:0];
      SLOT_HI: dout = word_q[WORD_W-1:DQ_W];
      default: dout = '0;
    endcase
  end

  assign dvalid = (slot_q != SLOT_NONE);
  assign oe     = (slot_q != SLOT_NONE);

  // R5: two beats follow a read command after two cycles
  p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |-> ##2 dvalid ##1 dvalid);
  // R7: valid only in slots owed to an earlier read
  p_valid_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> ($past(rd_cmd, 2) || $past(rd_cmd, 3)));
  // R10: the data output is quiet outside read slots
  p_quiet_dout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dvalid |-> (dout == '0));
endmodule

// File: rtl/b2_sram_front.sv
module b2_sram_front #(
  parameter int DQ_W   = 18,
  parameter int BYTES  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   din,
  input  logic [BYTES-1:0]  bw_n,
  output logic [DQ_W-1:0]   dout,
  output logic              dout_oe,
  output logic              dvalid
);
  localparam int WORD_W = 2 * DQ_W;
  localparam int WLANES = 2 * BYTES;

  logic              srst_n;
  logic              cmd_live, rd_cmd, wr_cmd;
  logic              pend_v, wr_capture;
  logic [ADDR_W-1:0] pend_addr, rd_addr;
  logic [WORD_W-1:0] pend_data, rd_word;
  logic [WLANES-1:0] pend_wen;

  b2_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign cmd_live = srst_n & ~ld_n;
  assign rd_cmd   = cmd_live & rw;
  assign wr_cmd   = cmd_live & ~rw;

  b2_wr_gather #(.DQ_W(DQ_W), .BYTES(BYTES), .ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_cmd    (wr_cmd),
    .cmd_addr  (addr),
    .din       (din),
    .bw_n      (bw_n),
    .pend_v    (pend_v),
    .pend_addr (pend_addr),
    .pend_data (pend_data),
    .pend_wen  (pend_wen),
    .capturing (wr_capture)
  );

  b2_array #(.DQ_W(DQ_W), .BYTES(BYTES), .ADDR_W(ADDR_W)) u_arr (
    .clk       (clk),
    .pend_v    (pend_v),
    .pend_addr (pend_addr),
    .pend_data (pend_data),
    .pend_wen  (pend_wen),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word)
  );

  b2_rd_out #(.DQ_W(DQ_W), .ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (srst_n),
    .rd_cmd   (rd_cmd),
    .cmd_addr (addr),
    .rd_word  (rd_word),
    .rd_addr  (rd_addr),
    .dout     (dout),
    .dvalid   (dvalid),
    .oe       (dout_oe)
  );

  // R2: host rule, each command owns two beat slots
  p_cmd_gap_r2: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_live |=> !cmd_live);
  // R8: the bus is never driven while write beats are taken in
  p_no_turn_clash_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !(dout_oe && wr_capture));
  // R1: two idle cycles leave no write beat capture behind
  p_idle_no_capture_r1: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(ld_n) && $past(ld_n, 2)) |-> !wr_capture);
endmodule

// File: tb/tb_b2_sram_front.sv
module tb_b2_sram_front;
  localparam int CLK_NS = 10;
  localparam int DQ_W   = 18;
  localparam int BYTES  = 2;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 2 * DQ_W;
  localparam int LANE_W = DQ_W / BYTES;
  localparam int MAXT   = 1000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ld_n;
  logic              rw;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W-1:0]   din;
  logic [BYTES-1:0]  bw_n;
  logic [DQ_W-1:0]   dout;
  logic              dout_oe;
  logic              dvalid;

  b2_sram_front #(.DQ_W(DQ_W), .BYTES(BYTES), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .din(din), .bw_n(bw_n), .dout(dout), .dout_oe(dout_oe), .dvalid(dvalid)
  );

  always #(CLK_NS/2) clk = ~clk;

  // per-cycle schedule and expectations
  logic              p_ld_n [MAXT];
  logic              p_rw   [MAXT];
  logic [ADDR_W-1:0] p_addr [MAXT];
  logic [DQ_W-1:0]   p_din  [MAXT];
  logic [BYTES-1:0]  p_bw   [MAXT];
  logic              e_v    [MAXT];
  logic [DQ_W-1:0]   e_d    [MAXT];
  string             e_req  [MAXT];
  logic [WORD_W-1:0] model  [DEPTH];

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  task automatic check_eq(string req, string what, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic plan_wr(int t, int a, logic [DQ_W-1:0] d0, logic [BYTES-1:0] m0n,
                         logic [DQ_W-1:0] d1, logic [BYTES-1:0] m1n);
    logic [WORD_W-1:0] full;
    logic [WORD_W-1:0] w;
    p_ld_n[t] = 1'b0; p_rw[t] = 1'b0; p_addr[t] = ADDR_W'(a);
    p_din[t+1] = d0; p_bw[t+1] = m0n;
    p_din[t+2] = d1; p_bw[t+2] = m1n;
    full = {d1, d0};
    w = model[a];
    for (int i = 0; i < 2*BYTES; i++) begin
      logic mn;
      mn = (i < BYTES) ? m0n[i] : m1n[i-BYTES];
      if (!mn) w[i*LANE_W +: LANE_W] = full[i*LANE_W +: LANE_W];
    end
    model[a] = w;
  endtask

  task automatic plan_rd(int t, int a, string req);
    p_ld_n[t] = 1'b0; p_rw[t] = 1'b1; p_addr[t] = ADDR_W'(a);
    e_v[t+2] = 1'b1; e_d[t+2] = model[a][DQ_W-1:0];      e_req[t+2] = req;
    e_v[t+3] = 1'b1; e_d[t+3] = model[a][WORD_W-1:DQ_W]; e_req[t+3] = req;
  endtask

  initial begin
    int t;
    int last_rd;
    // idle defaults carry junk on every ignored input (R1)
    for (int i = 0; i < MAXT; i++) begin
      p_ld_n[i] = 1'b1;
      p_rw[i]   = 1'($urandom);
      p_addr[i] = ADDR_W'($urandom);
      p_din[i]  = DQ_W'($urandom);
      p_bw[i]   = BYTES'($urandom);
      e_v[i]    = 1'b0;
      e_d[i]    = '0;
      e_req[i]  = "R7";
    end
    for (int a = 0; a < DEPTH; a++) model[a] = '0;

    // R11: every address filled with its own word, then read back (R3, R5)
    for (int a = 0; a < DEPTH; a++)
      plan_wr(2*a, a, DQ_W'(a*37 + 5), '0, DQ_W'(a*91 + 1000), '0);
    for (int a = 0; a < DEPTH; a++)
      plan_rd(32 + 2*a, a, "R11");

    // R6: read lands while a partial write is still pending
    plan_wr(66, 5, 18'h1_2345, 2'b10, 18'h2_ABCD, 2'b01);
    plan_rd(68, 5, "R6");
    plan_rd(70, 5, "R4");
    // R6: two writes in a row to one address, read on the second
    plan_wr(74, 9, 18'h0_1111, 2'b00, 18'h3_2222, 2'b00);
    plan_wr(76, 9, 18'h2_7777, 2'b01, 18'h1_8888, 2'b11);
    plan_rd(78, 9, "R6");
    // R4: all lanes disabled keep the word unchanged
    plan_wr(82, 3, 18'h3_FFFF, 2'b11, 18'h3_FFFF, 2'b11);
    plan_rd(84, 3, "R4");
    // R2/R3: read, then write, then read the new word
    plan_rd(88, 1, "R2");
    plan_wr(91, 1, 18'h0_0F0F, 2'b00, 18'h3_F0F0, 2'b00);
    plan_rd(93, 1, "R3");
    // R1: long idle stretch with junk inputs, then read back
    plan_rd(110, 0, "R1");
    plan_rd(112, 3, "R1");

    // random phase keeping the command gaps
    t = 116; last_rd = 112;
    while (t < MAXT - 8) begin
      if ($urandom_range(0, 1) == 1) begin
        plan_rd(t, int'($urandom_range(0, DEPTH-1)), "R5");
        last_rd = t;
      end else begin
        if (t < last_rd + 3) t = last_rd + 3;
        plan_wr(t, int'($urandom_range(0, DEPTH-1)), DQ_W'($urandom), BYTES'($urandom),
                DQ_W'($urandom), BYTES'($urandom));
      end
      t += $urandom_range(2, 4);
    end

    // reset phase (R9)
    rst_n = 1'b0; ld_n = 1'b1; rw = 1'b0; addr = '0; din = '0; bw_n = '1;
    repeat (5) begin
      @(negedge clk);
      check_eq("R9", "dvalid in reset", WORD_W'(dvalid), '0);
      check_eq("R9", "oe in reset", WORD_W'(dout_oe), '0);
    end
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      check_eq("R9", "dvalid after reset", WORD_W'(dvalid), '0);
      check_eq("R9", "oe after reset", WORD_W'(dout_oe), '0);
      ld_n = 1'b1; rw = 1'($urandom); addr = ADDR_W'($urandom);
    end

    // run the schedule, checking every cycle before driving it
    for (int k = 0; k < MAXT; k++) begin
      @(negedge clk);
      if (e_v[k]) begin
        check_eq("R7", "dvalid", WORD_W'(dvalid), WORD_W'(1));
        check_eq("R8", "oe", WORD_W'(dout_oe), WORD_W'(1));
        check_eq(e_req[k], "read beat", WORD_W'(dout), WORD_W'(e_d[k]));
      end else begin
        check_eq("R7", "dvalid idle", WORD_W'(dvalid), '0);
        check_eq("R8", "oe idle", WORD_W'(dout_oe), '0);
        check_eq("R10", "dout idle", WORD_W'(dout), '0);
      end
      ld_n = p_ld_n[k]; rw = p_rw[k]; addr = p_addr[k];
      din  = p_din[k];  bw_n = p_bw[k];
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule